// File: doc/BRIEF.md
# Switch-on-Event Thread Controller

This block runs a small set of hardware thread contexts in block-interleaved fashion. One thread owns the fetch stage and keeps it on every cycle. It gives up the stage only when a latency event is reported against it, such as a cache miss. The controller then marks that thread as waiting. It picks the next ready thread in rotating order and holds a pipeline flush for a fixed number of cycles. After that the new thread starts fetching. A waiting thread becomes ready again when its completion strobe arrives. If no thread is ready after a miss, the controller goes idle until a strobe arrives.

A second, optional mode adds a lightweight helper context that owns only a 9-bit program counter. This mode is enabled by an input. When it is on and the running thread reports a stall, fetch moves to the helper context without any flush. The helper's fetch address keeps the upper bits of the running thread's PC, so it always stays inside the same 512-instruction page. Fetch goes back to the running thread as soon as the stall clears.

Top module: `soe_thread_ctl`

## Requirements
- R1: While reset is asserted: `active_tid` is 0, `running` is 1, `flush` is 0 and `fetch_nano` is 0. All threads start ready.
- R2: While `running` is 1 and no accepted miss arrives, `running` stays 1 and `active_tid` stays unchanged on every cycle.
- R3: A miss is accepted when `miss_valid` is 1, `running` is 1 and `miss_tid` equals `active_tid`. After the next clock edge:
  - `running` is 0.
  - If another thread is ready, `flush` is 1 and `active_tid` holds the chosen thread.
  - The chosen thread is the first ready one when searching upward from `active_tid`+1, modulo the thread count.
- R4: `flush` stays 1 for exactly `FLUSH_CYC` consecutive cycles. After that, `running` is 1 with the new `active_tid`.
- R5: A miss whose `miss_tid` differs from `active_tid` has no effect. So does any miss presented while `flush` is 1 or while the block is idle.
- R6: A thread is waiting from an accepted miss until a cycle in which its bit of `done_vec` is 1. The thread search skips waiting threads. If a thread's completion bit and an accepted miss for that same thread arrive in the same cycle, the thread ends up waiting.
- R7: If an accepted miss leaves no other thread ready, the block goes idle: `running` and `flush` are both 0.
  - The block stays idle until some `done_vec` bit is 1.
  - In that cycle it selects a thread, searching upward from `active_tid`+1 with `active_tid` itself considered last.
  - It then enters the flush of R4.
- R8: `fetch_nano` is 1 exactly when `nano_mode`, `stall` and `running` are all 1. While it is 1, `fetch_addr` equals {`main_pc`[PC_W-1:9], helper PC}.
- R9: The helper PC is 9 bits wide.
  - It loads `nano_load_pc` on a cycle with `nano_load` at 1; a load takes priority over an increment.
  - Otherwise, it increments by one, wrapping from 511 to 0, on every cycle in which `fetch_nano` is 1.
- R10: Whenever `fetch_nano` is 0, `fetch_addr` equals `main_pc`. This includes every cycle in which `nano_mode` is 0, whatever `stall` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Latency event reported this cycle |
| miss_tid | input | TW | Thread the event belongs to |
| done_vec | input | NTHR | Per-thread completion strobes |
| stall | input | 1 | Running thread is stalled this cycle |
| nano_mode | input | 1 | Enables fetch from the helper context on stall |
| nano_load | input | 1 | Load the helper PC |
| nano_load_pc | input | 9 | Value loaded into the helper PC |
| main_pc | input | PC_W | Fetch PC of the active thread |
| active_tid | output | TW | Thread currently owning the fetch stage |
| running | output | 1 | Active thread is fetching |
| flush | output | 1 | Pipeline flush request during a switch |
| fetch_nano | output | 1 | Fetch PC select: 1 selects the helper context |
| fetch_addr | output | PC_W | Selected fetch address |

## Verification
If the waiting mask is corrupted, the error does not show at once. It appears only at the next accepted miss or idle wake-up, when `active_tid` lands on the wrong thread or the block idles wrongly. For this reason the bench mixes random miss, completion and stall patterns over thousands of cycles and compares every output on every clock. Sequencing errors appear within one cycle, as a wrong `running` or `flush` value or an early or late end of the flush window. A helper-PC error appears on the next cycle in which `fetch_nano` is 1, in the low nine bits of `fetch_addr`.

// File: rtl/soe_thread_ctl.sv
module soe_thread_ctl #(
  parameter int NTHR      = 4,
  parameter int FLUSH_CYC = 3,
  parameter int PC_W      = 32,
  localparam int NPC_W    = 9,
  localparam int TW       = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int FCW      = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic [TW-1:0]    miss_tid,
  input  logic [NTHR-1:0]  done_vec,
  input  logic             stall,
  input  logic             nano_mode,
  input  logic             nano_load,
  input  logic [NPC_W-1:0] nano_load_pc,
  input  logic [PC_W-1:0]  main_pc,
  output logic [TW-1:0]    active_tid,
  output logic             running,
  output logic             flush,
  output logic             fetch_nano,
  output logic [PC_W-1:0]  fetch_addr
);

  typedef enum logic [1:0] {S_RUN, S_FLUSH, S_IDLE} st_t;

  st_t              st;
  logic [TW-1:0]    act;
  logic [NTHR-1:0]  wait_q, wait_nx;
  logic [FCW-1:0]   fcnt;
  logic [NPC_W-1:0] npc;
  logic             miss_ok, found;
  logic [TW-1:0]    pick;

  assign miss_ok = miss_valid && (st == S_RUN) && (miss_tid == act);
  assign wait_nx = (wait_q & ~done_vec) | (miss_ok ? (NTHR'(1) << act) : '0);

  always_comb begin
    found = 1'b0;
    pick  = act;
    for (int k = 1; k <= NTHR; k++) begin
      if (!found && !wait_nx[TW'((int'(act) + k) % NTHR)]) begin
        found = 1'b1;
        pick  = TW'((int'(act) + k) % NTHR);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RUN;
      act    <= '0;
      wait_q <= '0;
      fcnt   <= '0;
    end else begin
      wait_q <= wait_nx;
      case (st)
        S_RUN, S_IDLE: begin
          if (miss_ok || st == S_IDLE) begin
            if (found) begin
              act  <= pick;
              st   <= S_FLUSH;
              fcnt <= FCW'(FLUSH_CYC - 1);
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: begin
          if (fcnt == '0) st <= S_RUN;
          else fcnt <= fcnt - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) npc <= '0;
    else if (nano_load) npc <= nano_load_pc;
    else if (fetch_nano) npc <= npc + 1'b1;
  end

  assign active_tid = act;
  assign running    = (st == S_RUN);
  assign flush      = (st == S_FLUSH);
  assign fetch_nano = nano_mode && stall && running;
  assign fetch_addr = fetch_nano ? {main_pc[PC_W-1:NPC_W], npc} : main_pc;

  int   flen;
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flen    <= 0;
      past_ok <= 1'b0;
    end else begin
      flen    <= flush ? flen + 1 : 0;
      past_ok <= 1'b1;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(miss_valid && miss_tid == active_tid)) |=> (running && $stable(active_tid)));

  assert_leave_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && miss_valid && miss_tid == active_tid) |=> !running);

  assert_flush_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> (flen == FLUSH_CYC && running));

  assert_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_nano |-> (fetch_addr[PC_W-1:NPC_W] == main_pc[PC_W-1:NPC_W]));

  assert_nano_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fetch_nano && $past(fetch_nano) && !$past(nano_load)) |->
      (fetch_addr[NPC_W-1:0] == NPC_W'($past(fetch_addr[NPC_W-1:0]) + 1'b1)));

  assert_main_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nano_mode |-> (fetch_addr == main_pc));

endmodule

// File: tb/sim_soe_thread_ctl.sv
module sim_soe_thread_ctl;
  localparam int N  = 4;
  localparam int FL = 3;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [1:0]    miss_tid = '0;
  logic [N-1:0]  done_vec = '0;
  logic          stall = 1'b0;
  logic          nano_mode = 1'b0;
  logic          nano_load = 1'b0;
  logic [8:0]    nano_load_pc = '0;
  logic [PW-1:0] main_pc = 32'h1234_5678;
  logic [1:0]    active_tid;
  logic          running, flush, fetch_nano;
  logic [PW-1:0] fetch_addr;

  soe_thread_ctl #(.NTHR(N), .FLUSH_CYC(FL), .PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_tid(miss_tid),
    .done_vec(done_vec), .stall(stall), .nano_mode(nano_mode), .nano_load(nano_load),
    .nano_load_pc(nano_load_pc), .main_pc(main_pc), .active_tid(active_tid),
    .running(running), .flush(flush), .fetch_nano(fetch_nano), .fetch_addr(fetch_addr));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit fin = 1'b0;
  string phase = "R1";

  // reference model: 0 run, 1 flush, 2 idle
  int m_act = 0, m_st = 0, m_fc = 0, m_npc = 0;
  bit m_wait [N];

  function automatic bit m_nano();
    return nano_mode && stall && (m_st == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_st = 0; m_fc = 0; m_npc = 0;
      for (int i = 0; i < N; i++) m_wait[i] = 1'b0;
    end else begin
      bit acc, fnd;
      int nxt;
      bit nf;
      nf  = m_nano();
      acc = miss_valid && (m_st == 0) && (int'(miss_tid) == m_act);
      for (int i = 0; i < N; i++) if (done_vec[i]) m_wait[i] = 1'b0;
      if (acc) m_wait[m_act] = 1'b1;
      if (m_st == 1) begin
        m_fc--;
        if (m_fc == 0) m_st = 0;
      end else if (acc || m_st == 2) begin
        fnd = 1'b0; nxt = m_act;
        for (int k = 1; k <= N; k++)
          if (!fnd && !m_wait[(m_act + k) % N]) begin fnd = 1'b1; nxt = (m_act + k) % N; end
        if (fnd) begin m_act = nxt; m_st = 1; m_fc = FL; end
        else m_st = 2;
      end
      if (nano_load) m_npc = int'(nano_load_pc);
      else if (nf) m_npc = (m_npc + 1) % 512;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      logic [PW-1:0] ea;
      bit en;
      en = m_nano();
      ea = en ? {main_pc[PW-1:9], 9'(m_npc)} : main_pc;
      total++;
      if (int'(active_tid) != m_act || running != (m_st == 0) || flush != (m_st == 1) ||
          fetch_nano != en || fetch_addr != ea) begin
        bad++;
        $display("FAIL %s t=%0t actual tid=%0d run=%0b fl=%0b nano=%0b addr=%h expected tid=%0d run=%0b fl=%0b nano=%0b addr=%h",
          phase, $time, active_tid, running, flush, fetch_nano, fetch_addr,
          m_act, m_st == 0, m_st == 1, en, ea);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic miss(int t);
    miss_valid = 1'b1; miss_tid = 2'(t); cyc(); miss_valid = 1'b0;
  endtask

  task automatic done(int t);
    done_vec = N'(1) << t; cyc(); done_vec = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1; bad++; total++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    @(negedge clk);
    total++;
    if (active_tid != 0 || running != 1 || flush != 0 || fetch_nano != 0) begin
      bad++;
      $display("FAIL R1 reset actual tid=%0d run=%0b fl=%0b nano=%0b expected tid=0 run=1 fl=0 nano=0",
        active_tid, running, flush, fetch_nano);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    phase = "R2"; cyc(10);
    phase = "R3"; miss(0);
    phase = "R4"; cyc(FL + 2);
    phase = "R5"; miss(3); cyc(2); miss(1); miss(1); miss(1); cyc(FL + 2);
    phase = "R6"; miss(2); cyc(FL + 2);
    phase = "R7"; miss(3); cyc(4); done(1); cyc(FL + 2);
    phase = "R6"; done_vec = 4'b0010; miss_valid = 1'b1; miss_tid = 2'd1; cyc();
    done_vec = '0; miss_valid = 1'b0; cyc(4); done(0); cyc(FL + 2);
    done(2); done(3); cyc(2);
    phase = "R9"; nano_mode = 1'b1; nano_load = 1'b1; nano_load_pc = 9'h1FE; cyc();
    nano_load = 1'b0; stall = 1'b1; cyc(5);
    phase = "R8"; main_pc = 32'hABCD_E000; cyc(2); stall = 1'b0; cyc(2);
    phase = "R10"; nano_mode = 1'b0; stall = 1'b1; cyc(4); stall = 1'b0;

    phase = "R3,R5,R6,R7,R8,R9";
    for (int i = 0; i < 4000; i++) begin
      miss_valid   = ($urandom % 4) == 0;
      miss_tid     = (($urandom % 3) == 0) ? 2'($urandom) : 2'(m_act);
      done_vec     = (($urandom % 3) == 0) ? N'($urandom) : '0;
      stall        = ($urandom % 3) == 0;
      if (i % 64 == 0) nano_mode = $urandom % 2;
      nano_load    = ($urandom % 16) == 0;
      nano_load_pc = 9'($urandom);
      main_pc      = $urandom;
      cyc();
    end
    miss_valid = 1'b0; done_vec = '0; stall = 1'b0; nano_load = 1'b0;
    cyc(3);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule